// File: doc/BRIEF.md
# Serial Nibble Register Access Slave

This block lets a host read and write a bank of sixteen 4-bit registers over three wires: a select line, a shift clock and a data line. The data line is split into a receive pin, a transmit pin and an output-enable pin, so that a pad ring or an FPGA I/O buffer can build the bidirectional pin. All three host pins are synchronised into the block's system clock. Edges of the shift clock are detected there, so the system clock must run several times faster than the shift clock.

Traffic is framed in groups of eight shift clocks. Each group has four control bits followed by a nibble. The first control bit is a don't-care. The remaining three choose read or write, whether the nibble is loaded into an internal address pointer, and whether the nibble is stored into the register that the pointer selects. When a read command arrives, the block drives the addressed nibble back during the next group. After that it returns to listening. Select low keeps the framing logic idle and the transmit pin disabled.

Top module: `sernib_slave`

## Requirements
- R1: While the select line is low, the output enable is 0, the group position is held at zero and any pending read is dropped. A group interrupted by select falling changes no register and no address.
- R2: Receive bits are taken on falling shift-clock edges. A group is 8 bits: bit 1 is ignored, then bit 2 = read/write (1 = read), bit 3 = address-load flag, bit 4 = data flag, then a nibble sent MSB first.
- R3: When the address-load flag is 1 and the data flag is 0, the nibble replaces the address pointer, whatever the read/write bit is.
- R4: When the data flag is 1 and both the read/write bit and the address-load flag are 0, the nibble is written to the register the address pointer names.
- R5: Every other flag combination changes neither the registers nor the pointer.
- R6: Read/write=1, address-load=1, data=0 is a read command: the nibble loads the pointer, and the addressed register is returned during the next group.
- R7: In the group after a read command, the output enable rises on the rising edge of shift clock 2. The data pin is 0 for clocks 2 to 4, and bits 3..0 of the register are driven on the rising edges of clocks 5 to 8.
- R8: The output enable falls on the rising edge of clock 1 of the following group. Bits received during a read-output group are not decoded.
- R9: After a read-output group, with select still high, the next group is decoded as a fresh command, so a write or another read can follow a read directly.
- R10: After reset all sixteen registers read as 0, the address pointer is 0 and the output enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the shift clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Host select, active high |
| sck | input | 1 | Host shift clock |
| sdi | input | 1 | Data line, receive side |
| sdo | output | 1 | Data line, transmit value |
| sdo_oe | output | 1 | Data line output enable |

## Verification
A wrong group position or pending-read flag appears in the very next group as the enable turning on at the wrong clock, or as a misplaced nibble on the transmit pin. A corrupted pointer or register is only visible through a later read. For that reason, every write and flag combination is followed, two groups later, by a read that exposes the stored value. Interrupted groups are checked in the same way, and so is any decoding of bits received during an output group.

// File: rtl/sernib_pkg.sv
package sernib_pkg;

  localparam int CTRL_W = 4;

  typedef struct packed {
    logic rd_cmd;
    logic ld_ptr;
    logic st_dat;
  } sernib_cmd_t;

  // flags: [2] read/write, [1] address-load, [0] data
  function automatic sernib_cmd_t decode_flags(input logic [CTRL_W-2:0] f);
    sernib_cmd_t c;
    c.rd_cmd = f[2] & f[1] & ~f[0];
    c.ld_ptr = f[1] & ~f[0];
    c.st_dat = f[0] & ~f[2] & ~f[1];
    return c;
  endfunction

endpackage

// File: rtl/sernib_sync.sv
module sernib_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else if (g == 0) stg[g] <= d;
        else stg[g] <= stg[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sernib_frame.sv
module sernib_frame
  import sernib_pkg::*;
#(
  parameter int NIB_W = 4,
  localparam int GL    = CTRL_W + NIB_W,
  localparam int CNT_W = $clog2(GL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_s,
  input  logic             sck_s,
  input  logic             sdi_s,
  output logic             rise,
  output logic [CNT_W-1:0] pos,
  output logic             rd_act,
  output logic [NIB_W-1:0] ptr,
  output logic             wr_en,
  output logic [NIB_W-1:0] wr_addr,
  output logic [NIB_W-1:0] wr_data
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(GL-1);

  logic             sck_q;
  logic             fall;
  logic [GL-3:0]    sh;
  logic [GL-2:0]    word;
  logic             at_end;
  sernib_cmd_t      cmd;

  assign fall   = en_s & sck_q & ~sck_s;
  assign rise   = en_s & ~sck_q & sck_s;
  assign word   = {sh, sdi_s};
  assign at_end = fall && (pos == LAST);
  assign cmd    = decode_flags(word[GL-2:NIB_W]);

  always_ff @(posedge clk) begin
    if (rst) sck_q <= 1'b0;
    else     sck_q <= sck_s;
  end

  always_ff @(posedge clk) begin
    if (rst || !en_s) begin
      pos    <= '0;
      sh     <= '0;
      rd_act <= 1'b0;
    end else if (fall) begin
      sh  <= word[GL-3:0];
      pos <= (pos == LAST) ? '0 : pos + 1'b1;
      if (pos == LAST) rd_act <= !rd_act && cmd.rd_cmd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr     <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (at_end && !rd_act) begin
        if (cmd.ld_ptr) ptr <= word[NIB_W-1:0];
        if (cmd.st_dat) begin
          wr_en   <= 1'b1;
          wr_addr <= ptr;
          wr_data <= word[NIB_W-1:0];
        end
      end
    end
  end

  assert_idle_when_deselected_R1: assert property (@(posedge clk) disable iff (rst)
    !en_s |=> (pos == '0) && !rd_act);

  assert_store_only_at_group_end_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(fall) && ($past(pos) == LAST) && !$past(rd_act));

endmodule

// File: rtl/sernib_regbank.sv
module sernib_regbank #(
  parameter int AW = 4,
  parameter int DW = 4,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];
  logic          clearing;
  logic [AW-1:0] clr_idx;

  // zeroing sweep through the single write port keeps the array RAM-shaped
  always_ff @(posedge clk) begin
    if (rst) begin
      clearing <= 1'b1;
      clr_idx  <= '0;
    end else if (clearing) begin
      clr_idx <= clr_idx + 1'b1;
      if (clr_idx == AW'(DEPTH-1)) clearing <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (clearing)   mem[clr_idx] <= '0;
    else if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end

  assert_sweep_bounded_R10: assert property (@(posedge clk) disable iff (rst)
    (clearing && clr_idx == AW'(DEPTH-1)) |=> !clearing);

endmodule

// File: rtl/sernib_drive.sv
module sernib_drive #(
  parameter int NIB_W = 4,
  parameter int GL    = 8,
  localparam int CNT_W    = $clog2(GL),
  localparam int DATA_POS = GL - NIB_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_s,
  input  logic             rise,
  input  logic [CNT_W-1:0] pos,
  input  logic             rd_act,
  input  logic [NIB_W-1:0] rd_data,
  output logic             oe,
  output logic             dout
);
  logic sel_bit;
  logic in_data;

  always_comb begin
    sel_bit = 1'b0;
    in_data = 1'b0;
    for (int k = 0; k < NIB_W; k++) begin
      if (int'(pos) == DATA_POS + k) begin
        sel_bit = rd_data[NIB_W-1-k];
        in_data = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en_s) begin
      oe   <= 1'b0;
      dout <= 1'b0;
    end else if (rise) begin
      if (pos == '0) begin
        oe   <= 1'b0;
        dout <= 1'b0;
      end else if (rd_act) begin
        if (pos == CNT_W'(1)) begin
          oe   <= 1'b1;
          dout <= 1'b0;
        end else if (in_data) begin
          dout <= sel_bit;
        end
      end
    end
  end

  assert_oe_off_when_deselected_R1: assert property (@(posedge clk) disable iff (rst)
    !en_s |=> !oe);

  assert_oe_turn_on_clock2_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(oe) |-> $past(rise) && ($past(pos) == CNT_W'(1)) && $past(rd_act));

  assert_dout_moves_on_rise_R7: assert property (@(posedge clk) disable iff (rst)
    (en_s && !rise) |=> $stable(dout) && $stable(oe));

endmodule

// File: rtl/sernib_slave.sv
module sernib_slave
  import sernib_pkg::*;
#(
  parameter int NIB_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic sck,
  input  logic sdi,
  output logic sdo,
  output logic sdo_oe
);
  localparam int GL    = CTRL_W + NIB_W;
  localparam int CNT_W = $clog2(GL);

  logic [2:0]       pins_s;
  logic             rise;
  logic [CNT_W-1:0] pos;
  logic             rd_act;
  logic [NIB_W-1:0] ptr;
  logic             wr_en;
  logic [NIB_W-1:0] wr_addr;
  logic [NIB_W-1:0] wr_data;
  logic [NIB_W-1:0] rd_data;

  sernib_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({sel, sck, sdi}), .q(pins_s)
  );

  sernib_frame #(.NIB_W(NIB_W)) u_frame (
    .clk(clk), .rst(rst),
    .en_s(pins_s[2]), .sck_s(pins_s[1]), .sdi_s(pins_s[0]),
    .rise(rise), .pos(pos), .rd_act(rd_act), .ptr(ptr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  sernib_regbank #(.AW(NIB_W), .DW(NIB_W)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(ptr), .rd_data(rd_data)
  );

  sernib_drive #(.NIB_W(NIB_W), .GL(GL)) u_drive (
    .clk(clk), .rst(rst), .en_s(pins_s[2]), .rise(rise), .pos(pos),
    .rd_act(rd_act), .rd_data(rd_data), .oe(sdo_oe), .dout(sdo)
  );

endmodule

// File: tb/sernib_slave_bench.sv
`timescale 1ns/100ps
module sernib_slave_bench;
  localparam int H  = 6;
  localparam int NV = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;
  int   n_chk = 0, n_bad = 0;
  bit   done  = 1'b0;

  always #2.5 clk = ~clk;

  sernib_slave u_sernib_slave (
    .clk(clk), .rst(rst), .sel(sel), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  // {group bits, check-output flag, expected nibble}
  localparam logic [12:0] VEC [NV] = '{
    {8'h23,1'b0,4'h0}, {8'h1A,1'b0,4'h0}, {8'h25,1'b0,4'h0}, {8'h9C,1'b0,4'h0},
    {8'h63,1'b0,4'h0}, {8'h1F,1'b1,4'hA}, {8'h65,1'b0,4'h0}, {8'h00,1'b1,4'hC},
    {8'h63,1'b0,4'h0}, {8'h00,1'b1,4'hA}, {8'h34,1'b0,4'h0}, {8'h17,1'b0,4'h0},
    {8'h63,1'b0,4'h0}, {8'h00,1'b1,4'h7}, {8'h64,1'b0,4'h0}, {8'h00,1'b1,4'h0},
    {8'h46,1'b0,4'h0}, {8'h58,1'b0,4'h0}, {8'h64,1'b0,4'h0}, {8'h00,1'b1,4'h0},
    {8'h6F,1'b0,4'h0}, {8'h00,1'b1,4'h0}, {8'h1B,1'b0,4'h0}, {8'h6F,1'b0,4'h0},
    {8'h00,1'b1,4'hB}, {8'h63,1'b0,4'h0}, {8'h00,1'b1,4'h7}, {8'hA2,1'b0,4'h0},
    {8'h15,1'b0,4'h0}, {8'h62,1'b0,4'h0}, {8'h63,1'b1,4'h5}, {8'h00,1'b0,4'h0}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic select_on();
    sel = 1'b1; wait_clk(5);
  endtask

  task automatic select_off();
    sel = 1'b0; sck = 1'b0; wait_clk(8);
  endtask

  // sends nb bits of b; with chk the output nibble and framing are checked (R7, R8)
  task automatic send(input logic [7:0] b, input bit chk, input logic [3:0] exp, input int nb);
    logic [3:0] got;
    bit pre_ok, oe_ok;
    got = '0; pre_ok = 1'b1; oe_ok = 1'b1;
    for (int i = 0; i < nb; i++) begin
      sdi = b[7-i];
      sck = 1'b1;
      wait_clk(H);
      if (i == 0) begin
        if (sdo_oe !== 1'b0) oe_ok = 1'b0;
      end else if (chk) begin
        if (sdo_oe !== 1'b1) pre_ok = 1'b0;
        if (i < 4 && sdo !== 1'b0) pre_ok = 1'b0;
        if (i >= 4) got[7-i] = sdo;
      end else if (sdo_oe !== 1'b0) oe_ok = 1'b0;
      sck = 1'b0;
      wait_clk(H);
    end
    check(oe_ok, "R8 enable low outside output clocks", sdo_oe, 0);
    if (chk) begin
      check(pre_ok, "R7 enable high and zeros before data", sdo, 0);
      check(got == exp, "R6 read nibble", got, exp);
    end
  endtask

  initial begin
    wait_clk(3000000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    wait_clk(6);
    rst = 1'b0;
    wait_clk(30);
    check(sdo_oe == 1'b0, "R10 enable off after reset", sdo_oe, 0);
    select_on();

    // table walk: R2 R3 R4 R5 R6 R8 R9 covered by the sequence
    for (int v = 0; v < NV; v++)
      send(VEC[v][12:5], VEC[v][4], VEC[v][3:0], 8);
    select_off();

    // R10: pointer resets to 0 and registers to 0
    rst = 1'b1; wait_clk(4); rst = 1'b0; wait_clk(30);
    check(sdo_oe == 1'b0, "R10 enable off after second reset", sdo_oe, 0);
    select_on();
    send(8'h15, 1'b0, 4'h0, 8);
    send(8'h60, 1'b0, 4'h0, 8);
    send(8'h00, 1'b1, 4'h5, 8);
    send(8'h6F, 1'b0, 4'h0, 8);
    send(8'h00, 1'b1, 4'h0, 8);

    // R1: truncated write has no effect
    send(8'h26, 1'b0, 4'h0, 8);
    send(8'h1E, 1'b0, 4'h0, 5);
    select_off();
    select_on();
    send(8'h66, 1'b0, 4'h0, 8);
    send(8'h00, 1'b1, 4'h0, 8);

    // R1: truncated address load leaves pointer at 6
    send(8'h29, 1'b0, 4'h0, 6);
    select_off();
    select_on();
    send(8'h13, 1'b0, 4'h0, 8);
    send(8'h66, 1'b0, 4'h0, 8);
    send(8'h00, 1'b1, 4'h3, 8);

    // R1: select falling mid-output releases the line
    send(8'h66, 1'b0, 4'h0, 8);
    for (int i = 0; i < 5; i++) begin
      sdi = 1'b0; sck = 1'b1; wait_clk(H);
      if (i < 4) begin sck = 1'b0; wait_clk(H); end
    end
    check(sdo_oe == 1'b1, "R7 enable on during output", sdo_oe, 1);
    sel = 1'b0;
    wait_clk(H);
    check(sdo_oe == 1'b0, "R1 enable off after deselect", sdo_oe, 0);
    sck = 1'b0; wait_clk(8);

    // R9: after reselect a fresh command is decoded
    select_on();
    send(8'h1D, 1'b0, 4'h0, 8);
    send(8'h66, 1'b0, 4'h0, 8);
    send(8'h00, 1'b1, 4'hD, 8);
    select_off();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule